// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block is the byte-wide host side of a floppy disk controller. The host writes an opcode and its parameter bytes into a data port, one byte per write. The block waits in an execution phase until the drive-side logic pulses a completion strobe. It then offers the result bytes for the host to read from the same port. A main status byte tells the host at all times whether the controller wants a byte, whether the next byte flows toward the host, and whether a command is in progress.

The block keeps a single present-cylinder value. A seek updates it, and both the sense-interrupt and read-ID results report it. The interrupt output is raised when a data command reaches its result phase or a seek completes. It drops when the host has read the last byte of the result phase that answers it. Media transfer, DMA and drive timing are handled elsewhere. The host uses a plain address/read/write bus, and read data is combinational from the address.

Top module: `fdc_cmd_seq`

## Requirements
- R1: Out of synchronous reset the status byte reads 0x80 and the interrupt output is low.
- R2: The status byte at offset 4 has bit 7 = ready for a byte, bit 6 = direction (1 = toward host), bit 4 = busy, and bit 5 is always 0. It reads 0x80 when idle awaiting an opcode, 0x90 while collecting parameters, 0x10 during execution and 0xD0 during the result phase.
- R3: Opcode bytes are matched in full. 0xE6 (read) and 0x16 (verify) take 8 parameter bytes, 0x0A (read ID) takes 1, 0x0F (seek) takes 2 and 0x08 (sense interrupt) takes none. Execution starts on the write of the last parameter byte.
- R4: Execution ends only on a completion strobe received during execution. The strobe has no effect in any other phase.
- R5: Read and verify return 7 bytes: ST0 = bits 2:0 of parameter 0 (head in bit 2, drive in bits 1:0), then 0x00, 0x00, then parameters 1, 2, 3 and 4 in that order.
- R6: Read ID returns 7 bytes: the same ST0, 0x00, 0x00, the present cylinder, the head bit (bit 2 of its parameter), 0x01, 0x02.
- R7: On completion of a seek, the present cylinder takes the value of parameter 1 and the interrupt rises. The block returns to the idle command phase with no result phase.
- R8: If the interrupt is high when sense interrupt is issued, the block returns 0x20 OR'd with the seek's head/drive bits, then the present cylinder. The interrupt falls after the second byte is read. If the interrupt is low, the block returns the single byte 0x80.
- R9: Any opcode other than those in R3 yields the single result byte 0x80, with the interrupt low, and the block then goes back to the idle command phase.
- R10: The interrupt is low throughout parameter collection and execution. It rises on entry to the result phase of read, verify and read ID. Reading the last result byte lowers it and returns the block to the idle phase in the next cycle. Accepting any opcode other than sense interrupt drops a pending interrupt.
- R11: A data-port write during execution or result is ignored. A data-port read outside the result phase returns 0x00 and changes no state.
- R12: Reads at offsets other than 4 and 5 return 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| rd | input | 1 | Read strobe; a data-port read advances the result index at the clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| exec_done | input | 1 | Completion pulse from the execution side |
| irq | output | 1 | Interrupt request |

## Verification
A wrong phase shows at once in the status byte, which the bench reads on every idle cycle. A miscounted parameter length shows as 0x90 where 0x10 is expected, one write early or late. A wrong result index or stale parameter store appears on the first data-port read of a result phase, as a byte out of sequence. A mishandled interrupt flag is caught within one cycle by the per-clock comparison against the reference model, including pending seek interrupts that a following opcode must discard.

// File: rtl/fdc_cmd_seq_pkg.sv
package fdc_cmd_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAX_PAR = 8;
    localparam int MAX_RES = 7;
    localparam int PCNT_W  = $clog2(MAX_PAR + 1);
    localparam int RIDX_W  = $clog2(MAX_RES + 1);

    localparam logic [BYTE_W-1:0] OP_READ    = 8'hE6;
    localparam logic [BYTE_W-1:0] OP_VERIFY  = 8'h16;
    localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h0A;
    localparam logic [BYTE_W-1:0] OP_SEEK    = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_SENSE   = 8'h08;

    localparam logic [BYTE_W-1:0] ST_INVALID   = 8'h80;
    localparam logic [BYTE_W-1:0] ST0_SEEK_END = 8'h20;

    localparam logic [BYTE_W-1:0] STAT_RQM  = 8'h80;
    localparam logic [BYTE_W-1:0] STAT_DIO  = 8'h40;
    localparam logic [BYTE_W-1:0] STAT_BUSY = 8'h10;

    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_PARAM  = 2'd1,
        PH_EXEC   = 2'd2,
        PH_RESULT = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        RK_NONE   = 3'd0,
        RK_XFER   = 3'd1,
        RK_ID     = 3'd2,
        RK_SENSE  = 3'd3,
        RK_STAT80 = 3'd4
    } res_kind_e;

    typedef struct packed {
        logic [PCNT_W-1:0] n_par;
        logic              is_seek;
        logic              is_sense;
        res_kind_e         kind;
    } op_info_t;

    function automatic logic [RIDX_W-1:0] res_count(res_kind_e k);
        case (k)
            RK_XFER, RK_ID: return RIDX_W'(MAX_RES);
            RK_SENSE:       return RIDX_W'(2);
            RK_STAT80:      return RIDX_W'(1);
            default:        return '0;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] status_of(phase_e ph);
        case (ph)
            PH_CMD:    return STAT_RQM;
            PH_PARAM:  return STAT_RQM | STAT_BUSY;
            PH_EXEC:   return STAT_BUSY;
            default:   return STAT_RQM | STAT_DIO | STAT_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
    import fdc_cmd_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    always_comb begin
        info = '{n_par: '0, is_seek: 1'b0, is_sense: 1'b0, kind: RK_STAT80};
        case (opcode)
            OP_READ, OP_VERIFY: begin
                info.n_par = PCNT_W'(MAX_PAR);
                info.kind  = RK_XFER;
            end
            OP_READ_ID: begin
                info.n_par = PCNT_W'(1);
                info.kind  = RK_ID;
            end
            OP_SEEK: begin
                info.n_par   = PCNT_W'(2);
                info.is_seek = 1'b1;
                info.kind    = RK_NONE;
            end
            OP_SENSE: begin
                info.is_sense = 1'b1;
                info.kind     = RK_SENSE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fdc_cmd_result.sv
module fdc_cmd_result
    import fdc_cmd_seq_pkg::*;
(
    input  res_kind_e                     kind,
    input  logic [RIDX_W-1:0]             idx,
    input  logic [MAX_PAR-1:0][BYTE_W-1:0] par,
    input  logic [BYTE_W-1:0]             pcn,
    input  logic [2:0]                    seek_sel,
    output logic [BYTE_W-1:0]             byte_o
);
    logic              xfer;
    logic [BYTE_W-1:0] st0;

    assign xfer = (kind == RK_XFER);
    assign st0  = {{(BYTE_W-3){1'b0}}, par[0][2:0]};

    always_comb begin
        byte_o = '0;
        case (kind)
            RK_XFER, RK_ID: begin
                case (idx)
                    RIDX_W'(0): byte_o = st0;
                    RIDX_W'(3): byte_o = xfer ? par[1] : pcn;
                    RIDX_W'(4): byte_o = xfer ? par[2] : {{(BYTE_W-1){1'b0}}, par[0][2]};
                    RIDX_W'(5): byte_o = xfer ? par[3] : 8'h01;
                    RIDX_W'(6): byte_o = xfer ? par[4] : 8'h02;
                    default:    byte_o = '0;
                endcase
            end
            RK_SENSE:  byte_o = (idx == '0) ? (ST0_SEEK_END | {{(BYTE_W-3){1'b0}}, seek_sel}) : pcn;
            RK_STAT80: byte_o = ST_INVALID;
            default:   byte_o = '0;
        endcase
    end
endmodule

// File: rtl/fdc_cmd_fsm.sv
module fdc_cmd_fsm
    import fdc_cmd_seq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           fifo_wr,
    input  logic                           fifo_rd,
    input  logic [BYTE_W-1:0]              wdata,
    input  logic                           exec_done,
    input  op_info_t                       info,
    output phase_e                         phase,
    output logic [BYTE_W-1:0]              status,
    output logic                           irq,
    output res_kind_e                      kind,
    output logic [RIDX_W-1:0]              ridx,
    output logic [MAX_PAR-1:0][BYTE_W-1:0] par,
    output logic [BYTE_W-1:0]              pcn,
    output logic [2:0]                     seek_sel
);
    phase_e            phase_q;
    logic [PCNT_W-1:0] npar_q, pcnt_q;
    logic              is_seek_q;
    res_kind_e         kind_q;
    logic [RIDX_W-1:0] rcnt_q, ridx_q;
    logic              irq_q;
    logic [BYTE_W-1:0] pcn_q;
    logic [2:0]        seek_sel_q;
    logic [MAX_PAR-1:0][BYTE_W-1:0] par_q;

    logic last_rd;
    assign last_rd = (phase_q == PH_RESULT) && fifo_rd && (ridx_q == rcnt_q - RIDX_W'(1));

    for (genvar g = 0; g < MAX_PAR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                par_q[g] <= '0;
            else if (phase_q == PH_PARAM && fifo_wr && pcnt_q == PCNT_W'(g))
                par_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_CMD;
            npar_q     <= '0;
            pcnt_q     <= '0;
            is_seek_q  <= 1'b0;
            kind_q     <= RK_NONE;
            rcnt_q     <= '0;
            ridx_q     <= '0;
            irq_q      <= 1'b0;
            pcn_q      <= '0;
            seek_sel_q <= '0;
        end else begin
            case (phase_q)
                PH_CMD: if (fifo_wr) begin
                    npar_q    <= info.n_par;
                    is_seek_q <= info.is_seek;
                    pcnt_q    <= '0;
                    ridx_q    <= '0;
                    if (info.is_sense) begin
                        phase_q <= PH_RESULT;
                        if (irq_q) begin
                            kind_q <= RK_SENSE;
                            rcnt_q <= res_count(RK_SENSE);
                        end else begin
                            kind_q <= RK_STAT80;
                            rcnt_q <= res_count(RK_STAT80);
                        end
                    end else begin
                        irq_q <= 1'b0;
                        if (info.n_par != '0) begin
                            phase_q <= PH_PARAM;
                            kind_q  <= info.kind;
                        end else begin
                            phase_q <= PH_RESULT;
                            kind_q  <= RK_STAT80;
                            rcnt_q  <= res_count(RK_STAT80);
                        end
                    end
                end
                PH_PARAM: if (fifo_wr) begin
                    pcnt_q <= pcnt_q + PCNT_W'(1);
                    if (pcnt_q == npar_q - PCNT_W'(1))
                        phase_q <= PH_EXEC;
                end
                PH_EXEC: if (exec_done) begin
                    irq_q <= 1'b1;
                    if (is_seek_q) begin
                        pcn_q      <= par_q[1];
                        seek_sel_q <= par_q[0][2:0];
                        phase_q    <= PH_CMD;
                    end else begin
                        phase_q <= PH_RESULT;
                        rcnt_q  <= res_count(kind_q);
                        ridx_q  <= '0;
                    end
                end
                default: if (fifo_rd) begin
                    if (last_rd) begin
                        phase_q <= PH_CMD;
                        irq_q   <= 1'b0;
                        ridx_q  <= '0;
                    end else begin
                        ridx_q <= ridx_q + RIDX_W'(1);
                    end
                end
            endcase
        end
    end

    assign phase    = phase_q;
    assign status   = status_of(phase_q);
    assign irq      = irq_q;
    assign kind     = kind_q;
    assign ridx     = ridx_q;
    assign par      = par_q;
    assign pcn      = pcn_q;
    assign seek_sel = seek_sel_q;

    assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PARAM || phase_q == PH_EXEC) |-> !irq_q);

    assert_last_read_R10: assert property (@(posedge clk) disable iff (rst)
        last_rd |=> (phase_q == PH_CMD && !irq_q));

    assert_hold_exec_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && !exec_done) |=> (phase_q == PH_EXEC));

    assert_ignore_wr_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RESULT && fifo_wr && !fifo_rd) |=> (phase_q == PH_RESULT && $stable(ridx_q)));

    assert_ignore_rd_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CMD && fifo_rd && !fifo_wr) |=> (phase_q == PH_CMD && $stable(irq_q)));

    assert_seek_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && exec_done && is_seek_q) |=> (irq_q && phase_q == PH_CMD));
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_cmd_seq_pkg::*;
#(
    parameter int              ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] STAT_OFF = 3'd4,
    parameter logic [ADDR_W-1:0] DATA_OFF = 3'd5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              exec_done,
    output logic              irq
);
    logic                           fifo_wr, fifo_rd;
    op_info_t                       info;
    phase_e                         phase;
    logic [BYTE_W-1:0]              status;
    res_kind_e                      kind;
    logic [RIDX_W-1:0]              ridx;
    logic [MAX_PAR-1:0][BYTE_W-1:0] par;
    logic [BYTE_W-1:0]              pcn;
    logic [2:0]                     seek_sel;
    logic [BYTE_W-1:0]              res_byte;

    assign fifo_wr = wr && (addr == DATA_OFF);
    assign fifo_rd = rd && (addr == DATA_OFF);

    fdc_cmd_decode i_decode (.opcode(wdata), .info(info));

    fdc_cmd_fsm i_fsm (
        .clk(clk), .rst(rst), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
        .wdata(wdata), .exec_done(exec_done), .info(info),
        .phase(phase), .status(status), .irq(irq), .kind(kind),
        .ridx(ridx), .par(par), .pcn(pcn), .seek_sel(seek_sel)
    );

    fdc_cmd_result i_result (
        .kind(kind), .idx(ridx), .par(par), .pcn(pcn),
        .seek_sel(seek_sel), .byte_o(res_byte)
    );

    always_comb begin
        if (addr == STAT_OFF)
            rdata = status;
        else if (addr == DATA_OFF && phase == PH_RESULT)
            rdata = res_byte;
        else
            rdata = '0;
    end

    assert_exec_stat_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == STAT_OFF && phase == PH_EXEC) |-> (!rdata[7] && rdata[4] && !rdata[5]));

    assert_idle_data_R11: assert property (@(posedge clk) disable iff (rst)
        (addr == DATA_OFF && phase != PH_RESULT) |-> (rdata == '0));
endmodule

// File: tb/test_fdc_cmd_seq.sv
module test_fdc_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = A_STAT;
    logic       rd = 1'b0, wr = 1'b0, exec_done = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0, failures = 0;
    bit done_run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_cmd_seq i_fdc_cmd_seq (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .exec_done(exec_done), .irq(irq)
    );

    // behavioural reference model
    int         m_ph = 0;  // 0 idle, 1 params, 2 exec, 3 result
    logic [7:0] m_op;
    logic [7:0] m_par[$];
    logic [7:0] m_res[$];
    bit         m_irq = 0;
    logic [7:0] m_pcn = 0;
    logic [2:0] m_sel = 0;
    int         m_need = 0;

    function automatic logic [7:0] m_stat();
        case (m_ph)
            0: return 8'h80;
            1: return 8'h90;
            2: return 8'h10;
            default: return 8'hD0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic m_write(logic [7:0] b);
        case (m_ph)
            0: begin
                m_op = b;
                if (b == 8'h08) begin
                    if (m_irq) m_res = '{8'h20 | {5'b0, m_sel}, m_pcn};
                    else       m_res = '{8'h80};
                    m_ph = 3;
                end else begin
                    m_irq = 0;
                    m_need = (b == 8'hE6 || b == 8'h16) ? 8 : (b == 8'h0A) ? 1 : (b == 8'h0F) ? 2 : 0;
                    m_par.delete();
                    if (m_need > 0) m_ph = 1;
                    else begin m_res = '{8'h80}; m_ph = 3; end
                end
            end
            1: begin
                m_par.push_back(b);
                if (m_par.size() == m_need) m_ph = 2;
            end
            default: ;
        endcase
    endtask

    task automatic m_done();
        if (m_ph != 2) return;
        m_irq = 1;
        if (m_op == 8'h0F) begin
            m_pcn = m_par[1];
            m_sel = m_par[0][2:0];
            m_ph = 0;
        end else begin
            logic [7:0] s0;
            s0 = {5'b0, m_par[0][2:0]};
            if (m_op == 8'h0A)
                m_res = '{s0, 8'h00, 8'h00, m_pcn, {7'b0, m_par[0][2]}, 8'h01, 8'h02};
            else
                m_res = '{s0, 8'h00, 8'h00, m_par[1], m_par[2], m_par[3], m_par[4]};
            m_ph = 3;
        end
    endtask

    // bus tasks
    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1;
        wr = 1'b0; addr = A_STAT;
        if (a == A_DATA) m_write(d);
    endtask

    task automatic bus_rd(logic [2:0] a, string req, output logic [7:0] got);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        got = rdata;
        if (a == A_STAT)                   exp = m_stat();
        else if (a == A_DATA && m_ph == 3) exp = m_res[0];
        else                               exp = 8'h00;
        chk(got == exp, req, got, exp);
        @(posedge clk);
        #1;
        rd = 1'b0; addr = A_STAT;
        if (a == A_DATA && m_ph == 3) begin
            void'(m_res.pop_front());
            if (m_res.size() == 0) begin m_ph = 0; m_irq = 0; end
        end
    endtask

    task automatic pulse_done();
        @(negedge clk);
        exec_done = 1'b1;
        @(posedge clk);
        #1;
        exec_done = 1'b0;
        m_done();
    endtask

    task automatic expect_byte(string req, logic [7:0] exp);
        logic [7:0] got;
        bus_rd(A_DATA, req, got);
        chk(got == exp, req, got, exp);
    endtask

    task automatic expect_stat(string req, logic [7:0] exp);
        logic [7:0] got;
        bus_rd(A_STAT, req, got);
        chk(got == exp, req, got, exp);
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #3;
        if (!rst && !done_run) begin
            chk(irq == m_irq, "R10 irq", irq, m_irq);
            if (addr == A_STAT) chk(rdata == m_stat(), "R2 status", rdata, m_stat());
        end
    end

    task automatic finish_run();
        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] g;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(rdata == 8'h80, "R1 status", rdata, 8'h80);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R12 other offsets read zero, writes ignored
        for (int a = 0; a < 8; a++)
            if (a != 4 && a != 5) bus_rd(3'(a), "R12 unused read", g);
        bus_wr(3'd2, 8'h08);
        bus_wr(3'd7, 8'hE6);
        expect_stat("R12 write ignored", 8'h80);

        // R11 read in command phase
        expect_byte("R11 idle read", 8'h00);
        expect_stat("R11 no advance", 8'h80);

        // R8 sense with nothing pending
        bus_wr(A_DATA, 8'h08);
        expect_stat("R2 result", 8'hD0);
        expect_byte("R8 no pending", 8'h80);
        expect_stat("R8 back idle", 8'h80);

        // R4 strobe outside execution
        pulse_done();
        expect_stat("R4 stray strobe", 8'h80);
        chk(irq == 1'b0, "R4 stray strobe irq", irq, 0);

        // R7 seek head 1 drive 2 to cylinder 5
        bus_wr(A_DATA, 8'h0F);
        expect_stat("R3 seek params", 8'h90);
        bus_wr(A_DATA, 8'h06);
        bus_wr(A_DATA, 8'h05);
        expect_stat("R3 seek exec", 8'h10);
        pulse_done();
        chk(irq == 1'b1, "R7 seek irq", irq, 1);
        expect_stat("R7 seek idle", 8'h80);

        // R8 sense with pending seek interrupt
        bus_wr(A_DATA, 8'h08);
        expect_byte("R8 st0", 8'h26);
        chk(irq == 1'b1, "R8 irq held", irq, 1);
        expect_byte("R8 pcn", 8'h05);
        chk(irq == 1'b0, "R8 irq cleared", irq, 0);

        // R5 read, R3 count, R4 hold, R11 ignored writes
        bus_wr(A_DATA, 8'hE6);
        begin
            logic [7:0] p[8] = '{8'h05, 8'h07, 8'h01, 8'h03, 8'h02, 8'h12, 8'h1B, 8'hFF};
            for (int i = 0; i < 8; i++) begin
                if (i == 7) expect_stat("R3 still params", 8'h90);
                bus_wr(A_DATA, p[i]);
            end
        end
        repeat (5) @(posedge clk);
        expect_stat("R4 waits", 8'h10);
        bus_wr(A_DATA, 8'h99);
        expect_stat("R11 exec write", 8'h10);
        pulse_done();
        chk(irq == 1'b1, "R10 result irq", irq, 1);
        bus_wr(A_DATA, 8'h42);
        expect_byte("R5 st0", 8'h05);
        expect_byte("R5 st1", 8'h00);
        expect_byte("R5 st2", 8'h00);
        expect_byte("R5 c", 8'h07);
        expect_byte("R5 h", 8'h01);
        expect_byte("R5 r", 8'h03);
        chk(irq == 1'b1, "R10 irq before last", irq, 1);
        expect_byte("R5 n", 8'h02);
        chk(irq == 1'b0, "R10 irq after last", irq, 0);
        expect_stat("R10 idle", 8'h80);

        // R5 verify
        bus_wr(A_DATA, 8'h16);
        begin
            logic [7:0] q[8] = '{8'h02, 8'h4F, 8'h00, 8'h09, 8'h01, 8'h09, 8'h1B, 8'hFF};
            for (int i = 0; i < 8; i++) bus_wr(A_DATA, q[i]);
        end
        pulse_done();
        expect_byte("R5 v st0", 8'h02);
        expect_byte("R5 v st1", 8'h00);
        expect_byte("R5 v st2", 8'h00);
        expect_byte("R5 v c", 8'h4F);
        expect_byte("R5 v h", 8'h00);
        expect_byte("R5 v r", 8'h09);
        expect_byte("R5 v n", 8'h01);

        // R6 read ID head 1 drive 0
        bus_wr(A_DATA, 8'h0A);
        bus_wr(A_DATA, 8'h04);
        expect_stat("R3 read id exec", 8'h10);
        pulse_done();
        expect_byte("R6 st0", 8'h04);
        expect_byte("R6 st1", 8'h00);
        expect_byte("R6 st2", 8'h00);
        expect_byte("R6 c", 8'h05);
        expect_byte("R6 h", 8'h01);
        expect_byte("R6 r", 8'h01);
        expect_byte("R6 n", 8'h02);

        // R9 invalid opcode, and it drops a pending seek interrupt
        bus_wr(A_DATA, 8'h0F);
        bus_wr(A_DATA, 8'h00);
        bus_wr(A_DATA, 8'h11);
        pulse_done();
        chk(irq == 1'b1, "R7 second seek", irq, 1);
        bus_wr(A_DATA, 8'h55);
        chk(irq == 1'b0, "R9 irq dropped", irq, 0);
        expect_stat("R9 result", 8'hD0);
        expect_byte("R9 invalid", 8'h80);
        expect_stat("R9 idle", 8'h80);
        bus_wr(A_DATA, 8'h08);
        expect_byte("R10 pending discarded", 8'h80);

        // R6 read ID reflects new cylinder
        bus_wr(A_DATA, 8'h0A);
        bus_wr(A_DATA, 8'h01);
        pulse_done();
        expect_byte("R6 st0 b", 8'h01);
        expect_byte("R6 st1 b", 8'h00);
        expect_byte("R6 st2 b", 8'h00);
        expect_byte("R6 c b", 8'h11);
        expect_byte("R6 h b", 8'h00);
        expect_byte("R6 r b", 8'h01);
        expect_byte("R6 n b", 8'h02);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule